// File: doc/BRIEF.md
# Prescaled Reference Divider

This block turns a fast reference clock into the slow comparison pulse that a phase comparator needs. The division has two stages. A fixed divide-by-8 stage produces one enable tick every eight clocks. An 11-bit programmable counter then counts those ticks up to a limit B. The overall ratio is therefore 8·B. Legal B settings run from 5 to 2047, which gives ratios from 40 to 16376.

Each completed division cycle produces one output pulse, one clock wide. A run input switches the divider between operation and a low-power standby. Standby clears both stages, so counting always restarts from a known point. The counter limit is read from the ratio input only when a new count begins. Because of this, a change in the setting never shortens or stretches a cycle that is already under way. Settings below the legal minimum are forced to the minimum.

Top module: `refdiv_top`

## Requirements
- R1: With `run` high, consecutive `ref_pulse` assertions are spaced exactly 8·B clocks apart, where B is the limit in force for that cycle, for every B from 5 to 2047.
- R2: A `ratio_b` value of 0, 1, 2, 3 or 4 is treated as 5, which gives a spacing of 40 clocks.
- R3: `ref_pulse` is high for exactly one clock per division cycle.
- R4: After `rst` is released with `run` high, `ref_pulse` stays low until the 8·B-th rising clock edge and rises at that edge. No partial cycle yields a pulse.
- R5: While `run` is low, `ref_pulse` stays low.
- R6: Lowering `run` in the middle of a cycle discards the partial count. After `run` rises again, the first pulse appears at the 8·B-th rising edge.
- R7: `ratio_b` is sampled only when a count begins: while `rst` is high, while `run` is low, or at the edge that ends a cycle. A change part-way through a cycle first affects the cycle that follows.
- R8: `rst` is synchronous and active high. On the clock after it is sampled high, `ref_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | High: divider operates; low: standby with both stages cleared |
| ratio_b | input | 11 | Programmed counter limit B (values below 5 act as 5) |
| ref_pulse | output | 1 | One-clock pulse at the end of each 8·B-clock cycle |

## Verification
The divider is exercised with limits at the legal floor (5), one step above it (6), several mid-range values and the top value 2047. Comparing their spacings shows that the counter limit and the fixed ×8 factor both enter the period. Settings of 0, 1 and 4 are expected to give the same 40-clock spacing as 5, which separates clamping from wrap-around or zero-length cycles. Directed sequences cover three further behaviours. Dropping `run` mid-count must restart from zero rather than resume. Changing `ratio_b` mid-cycle must give one old-length period and then one new-length period. A reset must hold the pulse low.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int unsigned PRE_DIV = 8;
    localparam int unsigned PRE_W   = $clog2(PRE_DIV);
    localparam int unsigned CNT_W   = 11;
    localparam int unsigned MIN_B   = 5;
    localparam int unsigned GAP_W   = CNT_W + PRE_W + 1;

    typedef logic [CNT_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t count;
        ratio_t limit;
    } stage_t;

    typedef enum logic {
        PH_HOLD  = 1'b0,
        PH_COUNT = 1'b1
    } phase_e;

    function automatic ratio_t clamp_ratio(input ratio_t b);
        if (b < ratio_t'(MIN_B)) begin
            return ratio_t'(MIN_B);
        end
        return b;
    endfunction

endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
    import refdiv_pkg::*;
(
    input  logic rst,
    input  logic run,
    output logic restart
);

    phase_e phase;

    always_comb begin
        if (rst || !run) begin
            phase = PH_HOLD;
        end else begin
            phase = PH_COUNT;
        end
    end

    assign restart = (phase == PH_HOLD);

endmodule

// File: rtl/refdiv_prescaler.sv
module refdiv_prescaler #(
    parameter int unsigned DIV = refdiv_pkg::PRE_DIV
) (
    input  logic clk,
    input  logic restart,
    output logic tick
);

    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase_cnt;

    always_ff @(posedge clk) begin
        if (restart) begin
            phase_cnt <= '0;
        end else if (phase_cnt == LAST) begin
            phase_cnt <= '0;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    assign tick = !restart && (phase_cnt == LAST);

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   restart,
    input  logic   tick,
    input  ratio_t ratio_in,
    output logic   wrap
);

    stage_t st;
    ratio_t last_idx;

    assign last_idx = ratio_t'(st.limit - ratio_t'(1));
    assign wrap     = tick && (st.count == last_idx);

    always_ff @(posedge clk) begin
        if (restart) begin
            st.count <= '0;
            st.limit <= clamp_ratio(ratio_in);
        end else if (wrap) begin
            st.count <= '0;
            st.limit <= clamp_ratio(ratio_in);
        end else if (tick) begin
            st.count <= st.count + 1'b1;
        end
    end

endmodule

// File: rtl/refdiv_pulse.sv
module refdiv_pulse (
    input  logic clk,
    input  logic restart,
    input  logic wrap,
    output logic pulse
);

    always_ff @(posedge clk) begin
        if (restart) begin
            pulse <= 1'b0;
        end else begin
            pulse <= wrap;
        end
    end

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
    parameter int unsigned PRE_DIV = refdiv_pkg::PRE_DIV
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic [refdiv_pkg::CNT_W-1:0] ratio_b,
    output logic                         ref_pulse
);

    logic restart;
    logic tick;
    logic wrap;

    refdiv_ctrl i_ctrl (
        .rst     (rst),
        .run     (run),
        .restart (restart)
    );

    refdiv_prescaler #(.DIV(PRE_DIV)) i_pre (
        .clk     (clk),
        .restart (restart),
        .tick    (tick)
    );

    refdiv_counter i_cnt (
        .clk      (clk),
        .restart  (restart),
        .tick     (tick),
        .ratio_in (ratio_b),
        .wrap     (wrap)
    );

    refdiv_pulse i_out (
        .clk     (clk),
        .restart (restart),
        .wrap    (wrap),
        .pulse   (ref_pulse)
    );

endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
    import refdiv_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   run,
    input ratio_t ratio_b,
    input logic   ref_pulse
);

    logic [GAP_W-1:0] gap;
    ratio_t           exp_b;
    ratio_t           prev_b;
    logic [GAP_W-1:0] exp_gap;

    assign exp_gap = GAP_W'(exp_b) * GAP_W'(PRE_DIV);

    // Observational model of the spacing between pulses
    always_ff @(posedge clk) begin
        prev_b <= ratio_b;
        if (rst || !run) begin
            gap   <= '0;
            exp_b <= clamp_ratio(ratio_b);
        end else if (ref_pulse) begin
            gap   <= GAP_W'(1);
            exp_b <= clamp_ratio(prev_b);
        end else begin
            gap   <= gap + 1'b1;
        end
    end

    // R1, R2, R4, R7: a pulse only after exactly 8*B clocks
    a_r1_period: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> (gap == exp_gap));

    a_r3_one_wide: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);

    a_r5_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        !run |=> !ref_pulse);

    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> !ref_pulse);

endmodule

bind refdiv_top refdiv_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .ratio_b   (ratio_b),
    .ref_pulse (ref_pulse)
);

// File: tb/test_refdiv_top.sv
module test_refdiv_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b1;
    logic [10:0] ratio_b = 11'd5;
    logic        ref_pulse;

    int checks = 0;
    int errors = 0;

    refdiv_top i_refdiv_top (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .ratio_b   (ratio_b),
        .ref_pulse (ref_pulse)
    );

    always #2 clk = ~clk;

    localparam int NV = 9;
    localparam logic [10:0] VEC_B [NV] = '{11'd5, 11'd6, 11'd0, 11'd1, 11'd4,
                                           11'd17, 11'd100, 11'd1023, 11'd2047};
    localparam int VEC_GAP [NV] = '{40, 48, 40, 40, 40, 136, 800, 8184, 16376};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count falling edges until ref_pulse is seen high, starting from 'start'
    task automatic measure(input int start, output int n);
        n = start;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_pulse && n < 20000);
    endtask

    task automatic do_reset(input logic [10:0] b);
        @(negedge clk);
        rst = 1'b1;
        run = 1'b1;
        ratio_b = b;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int bad;

        // R8: pulse low throughout reset
        bad = 0;
        repeat (6) begin
            @(negedge clk);
            if (ref_pulse) bad++;
        end
        check(bad == 0, "R8 reset holds pulse low", bad, 0);

        // Vector walk: R1, R2, R3, R4
        for (int i = 0; i < NV; i++) begin
            do_reset(VEC_B[i]);
            measure(0, n);
            check(n == VEC_GAP[i], $sformatf("R4 R2 first pulse b=%0d", VEC_B[i]), n, VEC_GAP[i]);
            @(negedge clk);
            check(ref_pulse == 1'b0, "R3 pulse one clock wide", int'(ref_pulse), 0);
            measure(1, n);
            check(n == VEC_GAP[i], $sformatf("R1 R2 period b=%0d", VEC_B[i]), n, VEC_GAP[i]);
        end

        // R5 and R6: standby in mid-count, then wake
        do_reset(11'd5);
        repeat (20) @(negedge clk);
        run = 1'b0;
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (ref_pulse) bad++;
        end
        check(bad == 0, "R5 no pulse in standby", bad, 0);
        run = 1'b1;
        measure(0, n);
        check(n == 40, "R6 restart after wake", n, 40);

        // R7: change of B mid-cycle takes effect at next reload
        do_reset(11'd5);
        measure(0, n);
        check(n == 40, "R7 baseline period", n, 40);
        n = 0;
        bad = 0;
        repeat (10) begin
            @(negedge clk);
            n++;
            if (ref_pulse) bad++;
        end
        ratio_b = 11'd10;
        measure(n, n);
        check(n == 40 && bad == 0, "R7 current cycle keeps old B", n, 40);
        measure(0, n);
        check(n == 80, "R7 next cycle uses new B", n, 80);

        // R8: reset in mid-count gives a fresh cycle
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(ref_pulse == 1'b0, "R8 pulse low after reset", int'(ref_pulse), 0);
        rst = 1'b0;
        measure(0, n);
        check(n == 80, "R4 full cycle after mid-count reset", n, 80);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule